// File: doc/BRIEF.md
# FET Control Integrating Deglitch Filter

This block cleans up two external control levels before they reach the charge and discharge FET drivers. Each control level has already been turned into a digital bit outside the block. It first passes through a two-flop synchronizer. On every sample tick from a shared divider, the synchronized bit is fed to a saturating up/down counter. A filtered state follows the counter with hysteresis. The state turns on once the count climbs past 70% of full range. It turns off once the count drops under 30%. Between those two points it keeps its last value.

Each FET enable output is the protection request for that FET ANDed with the filtered state of its own channel. A channel that is filtered off therefore forces its FET off, whatever the protection logic asks for. The two channels share nothing except the clock, the reset and the sample tick.

With the default parameters, the full range is 100 counts and the tick comes every 25000 clocks. At a 250 MHz clock that is a 100 us tick. A steady level then needs 71 ticks, about 7.1 ms, to move the state from the opposite saturated end.

Top module: `fet_ctl_filter`

## Requirements
- R1: While rst_ni is low, and in the cycles right after it is released, both FET enable outputs are 0. Both counters start at 0 and both filtered states start off.
- R2: While a channel's filtered state is off, its FET enable output is 0 whatever the protection request is.
- R3: While a channel's filtered state is on, its FET enable output equals its protection request in the same cycle.
- R4: The charge control input affects only fet_chg_en_o, and the discharge control input affects only fet_dsg_en_o.
- R5: A control level of 1 means enable. On each sample tick the counter steps up by one for a synchronized 1 and down by one for a 0. The state turns on when count*10 > 7*FULL_CNT. With FULL_CNT=10, a steady 1 applied from count 0 turns the state on at the 8th tick and not before.
- R6: The state turns off when count*10 < 3*FULL_CNT. With FULL_CNT=10, a steady 0 applied from full count turns the state off at the 8th tick and not before.
- R7: While the count stays between the two thresholds, the filtered state keeps its previous value.
- R8: The counter saturates at 0 and at FULL_CNT and never wraps. A long hold at either end does not shorten or lengthen the next transition.
- R9: Single-tick pulses of the opposite level, each followed by a tick of the held level, never change the filtered state.
- R10: A 50% duty toggle of the control level, with equal on and off tick counts, leaves the filtered state at its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_chg_i | input | 1 | Charge control level (1 = enable), asynchronous |
| ctrl_dsg_i | input | 1 | Discharge control level (1 = enable), asynchronous |
| prot_chg_i | input | 1 | Protection logic request for the charge FET |
| prot_dsg_i | input | 1 | Protection logic request for the discharge FET |
| fet_chg_en_o | output | 1 | Gated charge FET enable |
| fet_dsg_en_o | output | 1 | Gated discharge FET enable |

## Verification
The bench builds the block with FULL_CNT=10 and TICK_DIV=4. With these values the on threshold is reached at count 8 and the off threshold at count 2, and a whole transition from a saturated end takes about 32 clocks. A pulse lasting exactly four clocks then spans exactly one tick wherever it lands against the divider phase. That makes single-tick glitches and 50% duty toggles exact to drive. The windows before and after each threshold are sized to allow for both the synchronizer delay and the unknown tick phase.

// File: rtl/fet_filt_pkg.sv
package fet_filt_pkg;
  typedef enum logic {
    ST_OFF = 1'b0,
    ST_ON  = 1'b1
  } filt_state_e;

  localparam int NUM_CH = 2;
  localparam int CH_CHG = 0;
  localparam int CH_DSG = 1;
endpackage

// File: rtl/fet_sync2.sv
module fet_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fet_tick_gen.sv
module fet_tick_gen #(
  parameter int unsigned DIV = 25000  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(DIV);
  localparam logic [TW-1:0] LAST = TW'(DIV - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/fet_integ_chan.sv
module fet_integ_chan
  import fet_filt_pkg::*;
#(
  parameter int unsigned FULL_CNT = 100,
  parameter int unsigned CW       = $clog2(FULL_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          lvl_i,
  output logic [CW-1:0] cnt_o,
  output logic          en_o
);
  localparam logic [CW-1:0] TOP    = CW'(FULL_CNT);
  localparam int unsigned   ON_LIM = 7 * FULL_CNT;
  localparam int unsigned   OFF_LIM = 3 * FULL_CNT;

  logic [CW-1:0] cnt_q, cnt_d;
  filt_state_e   st_q, st_d;
  logic          above_on, below_off;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (lvl_i && cnt_q != TOP)         cnt_d = cnt_q + 1'b1;
      else if (!lvl_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end
  end

  assign above_on  = (32'(cnt_d) * 32'd10) > ON_LIM;
  assign below_off = (32'(cnt_d) * 32'd10) < OFF_LIM;

  always_comb begin
    st_d = st_q;
    if (above_on)       st_d = ST_ON;
    else if (below_off) st_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= ST_OFF;
    end else begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = (st_q == ST_ON);
endmodule

// File: rtl/fet_ctl_filter.sv
module fet_ctl_filter
  import fet_filt_pkg::*;
#(
  parameter int unsigned FULL_CNT = 100,
  parameter int unsigned TICK_DIV = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_chg_i,
  input  logic ctrl_dsg_i,
  input  logic prot_chg_i,
  input  logic prot_dsg_i,
  output logic fet_chg_en_o,
  output logic fet_dsg_en_o
);
  localparam int unsigned CW = $clog2(FULL_CNT + 1);

  logic                           tick;
  logic [NUM_CH-1:0]              ctrl_raw, ctrl_sync, prot_req, chan_en, fet_en;
  logic [NUM_CH-1:0][CW-1:0]      chan_cnt;

  assign ctrl_raw[CH_CHG] = ctrl_chg_i;
  assign ctrl_raw[CH_DSG] = ctrl_dsg_i;
  assign prot_req[CH_CHG] = prot_chg_i;
  assign prot_req[CH_DSG] = prot_dsg_i;

  fet_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    fet_sync2 sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ctrl_raw[ch]),
      .q_o   (ctrl_sync[ch])
    );

    fet_integ_chan #(.FULL_CNT(FULL_CNT), .CW(CW)) filt_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .lvl_i (ctrl_sync[ch]),
      .cnt_o (chan_cnt[ch]),
      .en_o  (chan_en[ch])
    );

    // filtered disable overrides the protection request
    assign fet_en[ch] = prot_req[ch] & chan_en[ch];
  end

  assign fet_chg_en_o = fet_en[CH_CHG];
  assign fet_dsg_en_o = fet_en[CH_DSG];
endmodule

// File: rtl/fet_ctl_filter_chk.sv
module fet_ctl_filter_chk
  import fet_filt_pkg::*;
#(
  parameter int unsigned FULL_CNT = 100,
  parameter int unsigned CW       = $clog2(FULL_CNT + 1)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0][CW-1:0] cnt,
  input logic [NUM_CH-1:0]         en,
  input logic [NUM_CH-1:0]         prot,
  input logic [NUM_CH-1:0]         fet
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    logic in_band;
    assign in_band = (32'(cnt[ch]) * 32'd10 <= 7 * FULL_CNT) &&
                     (32'(cnt[ch]) * 32'd10 >= 3 * FULL_CNT);

    // R2
    off_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en[ch] |-> !fet[ch]);

    // R3
    on_follows_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en[ch] |-> (fet[ch] == prot[ch]));

    // R5
    turn_on_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en[ch]) |-> (32'(cnt[ch]) * 32'd10 > 7 * FULL_CNT));

    // R6
    turn_off_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en[ch]) |-> (32'(cnt[ch]) * 32'd10 < 3 * FULL_CNT));

    // R7
    band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_band && $past(in_band)) |-> $stable(en[ch]));

    // R8
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(cnt[ch]) <= FULL_CNT);

    // R8
    unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt[ch] == $past(cnt[ch])) ||
      ({1'b0, cnt[ch]} == {1'b0, $past(cnt[ch])} + 1'b1) ||
      ({1'b0, $past(cnt[ch])} == {1'b0, cnt[ch]} + 1'b1));
  end
endmodule

bind fet_ctl_filter fet_ctl_filter_chk #(.FULL_CNT(FULL_CNT), .CW(CW)) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt   (chan_cnt),
  .en    (chan_en),
  .prot  (prot_req),
  .fet   (fet_en)
);

// File: tb/fet_ctl_filter_tb_top.sv
module fet_ctl_filter_tb_top;
  localparam int unsigned FULL = 10;
  localparam int unsigned DIV  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_chg = 1'b0, ctrl_dsg = 1'b0;
  logic prot_chg = 1'b0, prot_dsg = 1'b0;
  logic fet_chg, fet_dsg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fet_ctl_filter #(.FULL_CNT(FULL), .TICK_DIV(DIV)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ctrl_chg_i  (ctrl_chg),
    .ctrl_dsg_i  (ctrl_dsg),
    .prot_chg_i  (prot_chg),
    .prot_dsg_i  (prot_dsg),
    .fet_chg_en_o(fet_chg),
    .fet_dsg_en_o(fet_dsg)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; ctrl_chg = 1'b1; ctrl_dsg = 1'b1; prot_chg = 1'b1; prot_dsg = 1'b1;
    cyc(6);
    chk("R1 chg in reset", fet_chg, 1'b0);
    chk("R1 dsg in reset", fet_dsg, 1'b0);
    ctrl_chg = 1'b0; ctrl_dsg = 1'b0;
    rst_ni = 1'b1;
    cyc(2);
    chk("R1 chg after reset", fet_chg, 1'b0);
    chk("R1 dsg after reset", fet_dsg, 1'b0);
    cyc(40);  // long hold at 0 (R8 low end)
  endtask

  task automatic t_rise;
    ctrl_chg = 1'b1; ctrl_dsg = 1'b1;
    cyc(28);  // at most 7 ticks seen
    chk("R5 chg before 8th tick", fet_chg, 1'b0);
    chk("R8 dsg no early rise after hold at 0", fet_dsg, 1'b0);
    cyc(8);   // at least 8 ticks seen
    chk("R5 chg after 8th tick", fet_chg, 1'b1);
    chk("R5 dsg after 8th tick", fet_dsg, 1'b1);
  endtask

  task automatic t_prot;
    prot_chg = 1'b0; #1;
    chk("R3 chg follows prot low", fet_chg, 1'b0);
    chk("R4 dsg untouched by chg prot", fet_dsg, 1'b1);
    cyc(1);
    prot_chg = 1'b1; prot_dsg = 1'b0; #1;
    chk("R3 chg follows prot high", fet_chg, 1'b1);
    chk("R3 dsg follows prot low", fet_dsg, 1'b0);
    cyc(1);
    prot_dsg = 1'b1;
  endtask

  task automatic t_hyst;
    cyc(60);  // long hold at full (R8 high end)
    ctrl_chg = 1'b0;
    cyc(28);
    chk("R7 chg held on inside band", fet_chg, 1'b1);
    chk("R4 dsg unaffected by chg ctrl", fet_dsg, 1'b1);
    cyc(8);
    chk("R6 chg off after 8th tick", fet_chg, 1'b0);
    cyc(40);
  endtask

  task automatic t_glitch;
    for (int i = 0; i < 10; i++) begin
      ctrl_chg = 1'b1; ctrl_dsg = 1'b0;
      cyc(4);
      ctrl_chg = 1'b0; ctrl_dsg = 1'b1;
      cyc(4);
      chk("R9 chg glitch held off", fet_chg, 1'b0);
      chk("R9 dsg glitch held on", fet_dsg, 1'b1);
    end
    cyc(4);
  endtask

  task automatic t_duty;
    for (int i = 0; i < 8; i++) begin
      ctrl_chg = 1'b1; ctrl_dsg = 1'b0;
      cyc(8);
      ctrl_chg = 1'b0; ctrl_dsg = 1'b1;
      cyc(8);
      chk("R10 chg 50% duty holds off", fet_chg, 1'b0);
      chk("R10 dsg 50% duty holds on", fet_dsg, 1'b1);
    end
  endtask

  task automatic t_override;
    prot_chg = 1'b1; prot_dsg = 1'b1;
    cyc(1);
    chk("R2 chg off overrides prot", fet_chg, 1'b0);
    prot_chg = 1'b0; #1;
    chk("R2 chg stays off", fet_chg, 1'b0);
    chk("R4 dsg on while chg off", fet_dsg, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rise();
    t_prot();
    t_hyst();
    t_glitch();
    t_duty();
    t_override();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule